// File: doc/BRIEF.md
# Masked burst address counter

This block generates the address for one port of a dual-port memory. A command loads a start address from the address input bus. After that the counter steps one location per clock for as long as count enable is high. It holds its value when count enable is low. The value on `cnt_addr` drives the memory's address decoder directly.

A mask register decides which low-order bits of the counter take part in counting. The counter therefore wraps inside an aligned window of 2^k locations, and the bits above the window stay fixed. When the counted field passes from all ones back to zero, the sticky flag `wrap_irq` goes high. Read commands copy either the counter or the mask onto a separate readback bus one cycle later. A counter reset input clears the counter at any time. The master reset sets the counter, the mask, the flag and the readback bus to their start values.

Top module: `burst_mask_counter`

## Requirements
- R1: With `cmd_vld` high and `cmd` = 2'b00 (load address), `cnt_addr` equals the `addr_in` value of that cycle after the next rising edge. The wrap flag is cleared at the same edge. An address load takes priority over counting.
- R2: With `cnt_en` high and no counter reset or address load, the counter increases by one at every rising edge. With `cnt_en` low, the counter keeps its value.
- R3: With the mask at all ones, the counter covers the whole address space and steps from the all-ones address to zero.
- R4: When `cnt_clr` is high, the counter becomes zero and the wrap flag becomes zero at the next edge. This overrides an address load and counting in the same cycle. It has no effect on the mask.
- R5: Only the bits enabled by the mask advance, and no carry reaches a masked-off bit. When the masked field is all ones, the next step sets the field to zero and leaves the upper bits unchanged.
- R6: An enabled step from a cycle in which the masked field is all ones sets `wrap_irq` at that edge. The flag stays high until a counter reset, an address load or the master reset.
- R7: With `cmd_vld` high and `cmd` = 2'b01 (load mask), the mask takes the longest run of ones in `addr_in` that starts at bit 0. Every bit from the first zero upward is forced to zero.
- R8: `cmd` = 2'b10 (read counter) puts the counter value of the command cycle on `rb_addr` after the next edge. `cmd` = 2'b11 (read mask) does the same with the mask value. In every other cycle `rb_addr` keeps its value.
- R9: After master reset `rst`, `cnt_addr` is zero, the mask is all ones, `wrap_irq` is low and `rb_addr` is zero.
- R10: A mask load and a counting step in the same cycle use the old mask for that step. With a zero mask, an enabled step leaves the counter unchanged and sets `wrap_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high master reset |
| cnt_clr | input | 1 | Counter reset, highest priority |
| cmd_vld | input | 1 | Qualifies `cmd` |
| cmd | input | 2 | 00 load address, 01 load mask, 10 read counter, 11 read mask |
| addr_in | input | ADDR_W | Address or mask value to be loaded |
| cnt_en | input | 1 | Step the counter by one this cycle |
| cnt_addr | output | ADDR_W | Current counter value |
| rb_addr | output | ADDR_W | Registered readback of the counter or the mask |
| wrap_irq | output | 1 | Sticky wrap-around flag |

## Verification
Two kinds of action can fall in the same cycle. First, a counting step can meet a counter reset or an address load; the bench drives these together and expects the priority order clear, then load, then step. Second, a mask load can meet a counting step that is about to wrap; the bench expects that step to use the mask held before the edge. Directed sequences set up both cases, and a long stretch of mixed random commands hits them often. A behavioural model computes the expected values on its own and is compared with every output after every clock.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        CMD_LD_ADDR = 2'b00,
        CMD_LD_MASK = 2'b01,
        CMD_RD_CNT  = 2'b10,
        CMD_RD_MASK = 2'b11
    } mbc_cmd_e;

    // Counter control for one cycle, decoded at the top.
    typedef struct packed {
        logic clr;
        logic load;
        logic step;
    } cnt_ctl_t;

    // Keep only the run of ones that starts at bit 0.
    function automatic logic [MAX_W-1:0] low_run(input logic [MAX_W-1:0] v);
        logic [MAX_W-1:0] r;
        logic             run;
        run = 1'b1;
        for (int i = 0; i < MAX_W; i++) begin
            run  = run & v[i];
            r[i] = run;
        end
        return r;
    endfunction

    // Advance only the field selected by the mask.
    function automatic logic [MAX_W-1:0] step_masked(input logic [MAX_W-1:0] c,
                                                     input logic [MAX_W-1:0] m);
        return (c & ~m) | ((c + 1) & m);
    endfunction

    function automatic logic field_full(input logic [MAX_W-1:0] c,
                                        input logic [MAX_W-1:0] m);
        return (c & m) == m;
    endfunction

endpackage

// File: rtl/mbc_mask_reg.sv
module mbc_mask_reg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] mask
);
    localparam int MW = mbc_pkg::MAX_W;

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (ld)
            mask <= ADDR_W'(mbc_pkg::low_run(MW'(din)));
    end

    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
        ld |=> ((mask & (mask + 1'b1)) == '0))  // R7
        else $error("mask not contiguous");

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(mask))  // R7
        else $error("mask changed without load");

endmodule

// File: rtl/mbc_counter.sv
module mbc_counter #(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  mbc_pkg::cnt_ctl_t   ctl,
    input  logic [ADDR_W-1:0]   din,
    input  logic [ADDR_W-1:0]   mask,
    output logic [ADDR_W-1:0]   cnt,
    output logic                irq
);
    localparam int MW = mbc_pkg::MAX_W;

    logic [ADDR_W-1:0] cnt_nxt;
    logic              at_top;

    always_comb begin
        cnt_nxt = ADDR_W'(mbc_pkg::step_masked(MW'(cnt), MW'(mask)));
        at_top  = mbc_pkg::field_full(MW'(cnt), MW'(mask));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else if (ctl.clr) begin
            cnt <= '0;
            irq <= 1'b0;
        end else if (ctl.load) begin
            cnt <= din;
            irq <= 1'b0;
        end else if (ctl.step) begin
            cnt <= cnt_nxt;
            if (at_top)
                irq <= 1'b1;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (cnt == '0 && !irq))  // R4
        else $error("counter reset failed");

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !ctl.clr) |=> (cnt == $past(din) && !irq))  // R1
        else $error("address load failed");

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.load && !ctl.step) |=> ($stable(cnt) && $stable(irq)))  // R2
        else $error("counter moved while idle");

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.load) |=> ((cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask))))  // R5
        else $error("masked-off bits changed");

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl.clr && !ctl.load) |=> irq)  // R6
        else $error("wrap flag dropped");

endmodule

// File: rtl/mbc_readback.sv
module mbc_readback #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cnt,
    input  logic              rd_mask,
    input  logic [ADDR_W-1:0] cnt,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] rb
);
    always_ff @(posedge clk) begin
        if (rst)
            rb <= '0;
        else if (rd_cnt)
            rb <= cnt;
        else if (rd_mask)
            rb <= mask;
    end

    AST_RB_CNT: assert property (@(posedge clk) disable iff (rst)
        rd_cnt |=> (rb == $past(cnt)))  // R8
        else $error("counter readback wrong");

    AST_RB_MASK: assert property (@(posedge clk) disable iff (rst)
        (rd_mask && !rd_cnt) |=> (rb == $past(mask)))  // R8
        else $error("mask readback wrong");

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_cnt && !rd_mask) |=> $stable(rb))  // R8
        else $error("readback changed without command");

endmodule

// File: rtl/burst_mask_counter.sv
module burst_mask_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              cmd_vld,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cnt_en,
    output logic [ADDR_W-1:0] cnt_addr,
    output logic [ADDR_W-1:0] rb_addr,
    output logic              wrap_irq
);
    import mbc_pkg::*;

    cnt_ctl_t          ctl;
    logic              ld_mask;
    logic              rd_cnt;
    logic              rd_mask;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        ctl.clr  = cnt_clr;
        ctl.load = cmd_vld && (cmd == CMD_LD_ADDR);
        ctl.step = cnt_en;
        ld_mask  = cmd_vld && (cmd == CMD_LD_MASK);
        rd_cnt   = cmd_vld && (cmd == CMD_RD_CNT);
        rd_mask  = cmd_vld && (cmd == CMD_RD_MASK);
    end

    mbc_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .ld   (ld_mask),
        .din  (addr_in),
        .mask (mask)
    );

    mbc_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .din  (addr_in),
        .mask (mask),
        .cnt  (cnt_addr),
        .irq  (wrap_irq)
    );

    mbc_readback #(.ADDR_W(ADDR_W)) u_rb (
        .clk     (clk),
        .rst     (rst),
        .rd_cnt  (rd_cnt),
        .rd_mask (rd_mask),
        .cnt     (cnt_addr),
        .mask    (mask),
        .rb      (rb_addr)
    );

    AST_WRAP_SET: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_clr && !ctl.load && ((cnt_addr & mask) == mask)) |=> wrap_irq)  // R6
        else $error("wrap flag not raised");

    AST_FULL_ROLL: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_clr && !ctl.load && (&mask) && (&cnt_addr)) |=> (cnt_addr == '0))  // R3
        else $error("full-range rollover wrong");

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cnt_addr == '0 && !wrap_irq && rb_addr == '0 && (&mask)))  // R9
        else $error("reset state wrong");

endmodule

// File: tb/sim_burst_mask_counter.sv
`timescale 1ns/1ps
module sim_burst_mask_counter;
    localparam int AW   = 8;
    localparam int FULL = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_clr = 1'b0;
    logic          cmd_vld = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [AW-1:0] addr_in = '0;
    logic          cnt_en = 1'b0;
    logic [AW-1:0] cnt_addr;
    logic [AW-1:0] rb_addr;
    logic          wrap_irq;

    always #2 clk = ~clk;

    burst_mask_counter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .cmd_vld(cmd_vld), .cmd(cmd),
        .addr_in(addr_in), .cnt_en(cnt_en), .cnt_addr(cnt_addr),
        .rb_addr(rb_addr), .wrap_irq(wrap_irq)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";
    int    m_cnt, m_mask, m_irq, m_rb;

    function automatic int run_from_zero(int v);
        int r = 0;
        for (int i = 0; i < AW; i++) begin
            if (((v >> i) & 1) == 0) break;
            r = r | (1 << i);
        end
        return r;
    endfunction

    // Behavioural reference, updated at each rising edge from settled inputs.
    always @(posedge clk) begin
        int n_cnt, n_mask, n_irq, n_rb;
        if (rst) begin
            m_cnt = 0; m_mask = FULL; m_irq = 0; m_rb = 0;
        end else begin
            n_cnt = m_cnt; n_mask = m_mask; n_irq = m_irq; n_rb = m_rb;
            if (cmd_vld && cmd == 2'b10) n_rb = m_cnt;
            if (cmd_vld && cmd == 2'b11) n_rb = m_mask;
            if (cmd_vld && cmd == 2'b01) n_mask = run_from_zero(int'(addr_in));
            if (cnt_clr) begin
                n_cnt = 0; n_irq = 0;
            end else if (cmd_vld && cmd == 2'b00) begin
                n_cnt = int'(addr_in); n_irq = 0;
            end else if (cnt_en) begin
                if ((m_cnt & m_mask) == m_mask) begin
                    n_cnt = m_cnt & ~m_mask & FULL;
                    n_irq = 1;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            m_cnt = n_cnt; m_mask = n_mask; m_irq = n_irq; m_rb = n_rb;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        check(cur_req, "cnt_addr", int'(cnt_addr), m_cnt);
        check(cur_req, "rb_addr", int'(rb_addr), m_rb);
        check(cur_req, "wrap_irq", int'(wrap_irq), m_irq);
    endtask

    task automatic drive(logic clr, logic vld, logic [1:0] c, int a, logic en);
        cnt_clr = clr; cmd_vld = vld; cmd = c; addr_in = AW'(a); cnt_en = en;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 2'b00, 0, 0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        cur_req = "R9";
        // R9: reset state; read mask shows all ones
        check("R9", "cnt after reset", int'(cnt_addr), 0);
        check("R9", "irq after reset", int'(wrap_irq), 0);
        drive(0, 1, 2'b11, 0, 0);
        check("R9", "mask after reset", int'(rb_addr), FULL);

        cur_req = "R1";
        drive(0, 1, 2'b00, 'h35, 0);
        check("R1", "loaded address", int'(cnt_addr), 'h35);
        cur_req = "R2";
        for (int i = 0; i < 5; i++) drive(0, 0, 2'b00, 0, 1);
        check("R2", "after five steps", int'(cnt_addr), 'h3A);
        idle(3);
        check("R2", "held value", int'(cnt_addr), 'h3A);

        cur_req = "R3";
        drive(0, 1, 2'b00, 'hFD, 0);
        for (int i = 0; i < 3; i++) drive(0, 0, 2'b00, 0, 1);
        check("R3", "rollover to zero", int'(cnt_addr), 0);
        check("R6", "wrap flag set", int'(wrap_irq), 1);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) drive(0, 0, 2'b00, 0, 1);
        check("R6", "flag sticky", int'(wrap_irq), 1);
        drive(0, 1, 2'b00, 'h10, 0);
        check("R6", "flag cleared by load", int'(wrap_irq), 0);

        cur_req = "R7";
        drive(0, 1, 2'b01, 'h0B, 0);
        drive(0, 1, 2'b11, 0, 0);
        check("R7", "non-contiguous mask trimmed", int'(rb_addr), 'h03);
        drive(0, 1, 2'b01, 'h07, 0);
        drive(0, 1, 2'b11, 0, 0);
        check("R7", "mask 07 kept", int'(rb_addr), 'h07);

        cur_req = "R5";
        drive(0, 1, 2'b00, 'hA5, 0);
        for (int i = 0; i < 3; i++) drive(0, 0, 2'b00, 0, 1);
        check("R5", "wrap inside window", int'(cnt_addr), 'hA0);
        check("R5", "window wrap flag", int'(wrap_irq), 1);
        for (int i = 0; i < 10; i++) drive(0, 0, 2'b00, 0, 1);
        check("R5", "upper bits fixed", int'(cnt_addr) & 'hF8, 'hA0);

        cur_req = "R8";
        drive(0, 1, 2'b10, 0, 1);
        check("R8", "counter readback", int'(rb_addr), 'hA2);
        idle(2);
        check("R8", "readback holds", int'(rb_addr), 'hA2);

        cur_req = "R4";
        drive(1, 1, 2'b00, 'h55, 1);
        check("R4", "clear beats load and step", int'(cnt_addr), 0);
        check("R4", "clear drops flag", int'(wrap_irq), 0);
        drive(0, 1, 2'b11, 0, 0);
        check("R4", "mask untouched by clear", int'(rb_addr), 'h07);

        cur_req = "R10";
        drive(0, 1, 2'b00, 'h07, 0);
        drive(0, 1, 2'b01, 'h0F, 1);
        check("R10", "step used old mask", int'(cnt_addr), 'h00);
        check("R10", "old-mask wrap flag", int'(wrap_irq), 1);
        drive(0, 1, 2'b01, 'h00, 0);
        drive(0, 1, 2'b00, 'h42, 0);
        drive(0, 0, 2'b00, 0, 1);
        check("R10", "zero mask holds", int'(cnt_addr), 'h42);
        check("R10", "zero mask flags", int'(wrap_irq), 1);

        cur_req = "R1 R2 R4 R5 R6 R7 R8 mixed";
        drive(0, 1, 2'b01, 'hFF, 0);
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 99));
            drive(r < 4, r >= 4 && r < 40, 2'($urandom), int'($urandom_range(0, FULL)),
                  ($urandom_range(0, 3) != 0));
        end

        cur_req = "R9";
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R9", "cnt after second reset", int'(cnt_addr), 0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule